// File: doc/BRIEF.md
# Packet Filter Program Sequencer

This block is the control core of a small packet-classifying engine. A program of 64-bit instructions is written into a local program store. A start pulse then makes the block step through the program. It keeps an accumulator, an index register, sixteen scratch words and a program counter. Register moves, scratch stores, immediate loads and all control flow are handled inside the block.

Two neighbours do the rest of the work. Loads that need packet bytes or the packet length go to a fetch unit. Arithmetic and the comparisons behind conditional branches go to an ALU/compare unit. Each neighbour uses a request that stays high until a one-cycle done comes back.

Branches can only move forward. A run ends at a return instruction, which reports how many bytes of the packet to keep; zero means drop. A run that walks off the end of the loaded program, or that meets an undefined opcode, ends with a length of zero and the error flag set.

Top module: `bpfSeq`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low.
- R2: A `start` pulse while idle raises `busy` on the next cycle. `busy` stays high until the run ends. The run ends with a one-cycle `done` pulse in the same cycle that `busy` falls. A `start` pulse while busy has no effect.
- R3: Scratch memory is 16 words, indexed by k[3:0]. Store-A (class 2) writes A there and store-X (class 3) writes X there. Load-to-A (class 0) and load-to-X (class 1) read a scratch word when mode op[7:5]=3, and load k itself when mode=0. A `start` clears A, X, the PC and every scratch word.
- R4: Class 7 copies X into A when op[7]=1, and copies A into X when op[7]=0.
- R5: Packet loads go to the fetch unit. These are class 0 with mode 1, 2 or 4 (fixed offset, X-relative offset, length) and class 1 with mode 4 or 5 (length, header-length byte). `fetchReq` stays high with `fetchOp`=opcode, `fetchK`=k and `fetchIdx`=X held stable until `fetchDone`. `fetchData` then goes to A for class 0 and to X for class 1.
- R6: Class 4 goes to the ALU unit with `aluA`=A, and `aluB`=X when op[3]=1 or k when op[3]=0. The request is held until `aluDone`, and `aluResult` is then written to A.
- R7: In class 5 with op[7:4]≠0, the comparison is done by the ALU unit. The PC then becomes PC+1+jt when `aluTrue` is high, and PC+1+jf when it is low. An offset of 0 falls through to the next instruction.
- R8: In class 5 with op[7:4]=0, the PC becomes PC+1+k, with k taken as an unsigned 32-bit value.
- R9: Class 6 ends the run with `acceptLen`=A when op[4]=1, or k when op[4]=0. `err` is low for such an end.
- R10: The run ends with `acceptLen`=0 and `err` high in two cases. The first is a PC at or beyond the loaded program length. The second is class 0 with mode 5, 6 or 7, or class 1 with mode 1, 2, 6 or 7.
- R11: An instruction is {opcode[63:48], jt[47:40], jf[39:32], k[31:0]}, and the class is op[2:0]. A write to address 0 sets the program length to 1. Any later write raises the length to the highest address written plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| progWe | input | 1 | Program store write enable |
| progAddr | input | 6 | Program store write address |
| progData | input | 64 | Instruction word to write |
| start | input | 1 | Begin a run from instruction 0 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| acceptLen | output | 32 | Bytes of the packet to keep |
| err | output | 1 | The run ended on a fault |
| fetchReq | output | 1 | Packet load request |
| fetchOp | output | 16 | Opcode of the load |
| fetchK | output | 32 | Constant field of the load |
| fetchIdx | output | 32 | Current index register |
| fetchDone | input | 1 | Fetch result valid |
| fetchData | input | 32 | Fetched value |
| aluReq | output | 1 | ALU/compare request |
| aluOp | output | 16 | Opcode of the operation |
| aluA | output | 32 | First operand (accumulator) |
| aluB | output | 32 | Second operand (X or k) |
| aluDone | input | 1 | ALU result valid |
| aluResult | input | 32 | Arithmetic result |
| aluTrue | input | 1 | Comparison outcome |

## Verification
The bench builds the block with its default 64-instruction store and 16 scratch words. It writes programs far shorter than the store, so running off the end, a huge unconditional skip and reloading a short program after a long one are all easy to reach. Scratch offsets up to 31 are used so that aliasing through k[3:0] is exercised. The fetch and ALU latencies vary from 0 to 3 cycles, which covers both back-to-back handshakes and long stalls with an early second start.

// File: rtl/bpfSeqPkg.sv
package bpfSeqPkg;
  localparam int PC_W = 34;  // wide enough for pc + 1 + 32-bit k without wrap

  typedef enum logic [2:0] {
    CL_LD = 3'd0, CL_LDX = 3'd1, CL_ST = 3'd2, CL_STX = 3'd3,
    CL_ALU = 3'd4, CL_JMP = 3'd5, CL_RET = 3'd6, CL_MISC = 3'd7
  } insnClassE;

  localparam logic [2:0] MODE_IMM = 3'd0;
  localparam logic [2:0] MODE_ABS = 3'd1;
  localparam logic [2:0] MODE_IND = 3'd2;
  localparam logic [2:0] MODE_MEM = 3'd3;
  localparam logic [2:0] MODE_LEN = 3'd4;
  localparam logic [2:0] MODE_HDR = 3'd5;

  typedef enum logic [2:0] {
    SRC_K, SRC_MEM, SRC_EXT, SRC_ALU, SRC_A, SRC_X
  } srcSelE;

  typedef struct packed {
    logic   clearAll;
    logic   pcStep;
    logic   pcJump;
    logic   pcBranch;
    logic   takeTrue;
    logic   wrA;
    logic   wrX;
    srcSelE src;
    logic   wrMem;
    logic   memFromX;
    logic   aluUseX;
    logic   finish;
    logic   retA;
    logic   retZero;
  } seqStrobeT;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import bpfSeqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic [7:0] op,
  input  logic      pcOk,
  input  logic      fetchDone,
  input  logic      aluDone,
  input  logic      aluTrue,
  output seqStrobeT st,
  output logic      busy,
  output logic      done,
  output logic      err,
  output logic      fetchReq,
  output logic      aluReq
);
  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_FETCH, S_ALU} stateE;

  stateE     state, nxt;
  insnClassE cls;
  logic [2:0] mode;
  logic      bad;

  assign cls  = insnClassE'(op[2:0]);
  assign mode = op[7:5];

  always_comb begin
    st      = '0;
    nxt     = state;
    bad     = 1'b0;
    st.aluUseX = op[3];
    unique case (state)
      S_IDLE: if (start) begin
        st.clearAll = 1'b1;
        nxt = S_EXEC;
      end
      S_EXEC: begin
        if (!pcOk) bad = 1'b1;
        else begin
          unique case (cls)
            CL_LD: unique case (mode)
              MODE_IMM: begin st.wrA = 1'b1; st.src = SRC_K;   st.pcStep = 1'b1; end
              MODE_MEM: begin st.wrA = 1'b1; st.src = SRC_MEM; st.pcStep = 1'b1; end
              MODE_ABS, MODE_IND, MODE_LEN: nxt = S_FETCH;
              default: bad = 1'b1;
            endcase
            CL_LDX: unique case (mode)
              MODE_IMM: begin st.wrX = 1'b1; st.src = SRC_K;   st.pcStep = 1'b1; end
              MODE_MEM: begin st.wrX = 1'b1; st.src = SRC_MEM; st.pcStep = 1'b1; end
              MODE_LEN, MODE_HDR: nxt = S_FETCH;
              default: bad = 1'b1;
            endcase
            CL_ST:  begin st.wrMem = 1'b1; st.pcStep = 1'b1; end
            CL_STX: begin st.wrMem = 1'b1; st.memFromX = 1'b1; st.pcStep = 1'b1; end
            CL_ALU: nxt = S_ALU;
            CL_JMP: if (op[7:4] == 4'd0) st.pcJump = 1'b1;
                    else nxt = S_ALU;
            CL_RET: begin st.finish = 1'b1; st.retA = op[4]; nxt = S_IDLE; end
            CL_MISC: begin
              if (op[7]) begin st.wrA = 1'b1; st.src = SRC_X; end
              else       begin st.wrX = 1'b1; st.src = SRC_A; end
              st.pcStep = 1'b1;
            end
            default: bad = 1'b1;
          endcase
        end
        if (bad) begin
          st = '0;
          st.finish  = 1'b1;
          st.retZero = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_FETCH: if (fetchDone) begin
        st.src    = SRC_EXT;
        st.wrA    = (cls == CL_LD);
        st.wrX    = (cls == CL_LDX);
        st.pcStep = 1'b1;
        nxt = S_EXEC;
      end
      S_ALU: if (aluDone) begin
        if (cls == CL_ALU) begin
          st.wrA = 1'b1; st.src = SRC_ALU; st.pcStep = 1'b1;
        end else begin
          st.pcBranch = 1'b1; st.takeTrue = aluTrue;
        end
        nxt = S_EXEC;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= nxt;
      done  <= st.finish;
      if (st.clearAll)    err <= 1'b0;
      else if (st.finish) err <= st.retZero;
    end
  end

  assign busy     = (state != S_IDLE);
  assign fetchReq = (state == S_FETCH);
  assign aluReq   = (state == S_ALU);
endmodule

// File: rtl/seqData.sv
module seqData
  import bpfSeqPkg::*;
#(
  parameter int PROG_DEPTH = 64,
  parameter int MEM_WORDS  = 16,
  localparam int ADDR_W = $clog2(PROG_DEPTH),
  localparam int MIDX_W = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         st,
  input  logic              progWe,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [63:0]       progData,
  input  logic [31:0]       fetchData,
  input  logic [31:0]       aluResult,
  output logic [15:0]       opcode,
  output logic [31:0]       kVal,
  output logic [31:0]       regA,
  output logic [31:0]       regX,
  output logic [31:0]       aluB,
  output logic              pcOk,
  output logic [31:0]       acceptLen
);
  logic [63:0]       progMem [PROG_DEPTH];
  logic [31:0]       scratch [MEM_WORDS];
  logic [PC_W-1:0]   pc;
  logic [ADDR_W:0]   progTop;
  logic [ADDR_W:0]   addrNext;
  logic [63:0]       insn;
  logic [7:0]        jt, jf;
  logic [31:0]       srcVal;
  logic [MIDX_W-1:0] mIdx;

  assign insn     = progMem[pc[ADDR_W-1:0]];
  assign opcode   = insn[63:48];
  assign jt       = insn[47:40];
  assign jf       = insn[39:32];
  assign kVal     = insn[31:0];
  assign mIdx     = kVal[MIDX_W-1:0];
  assign pcOk     = pc < PC_W'(progTop);
  assign aluB     = st.aluUseX ? regX : kVal;
  assign addrNext = {1'b0, progAddr} + 1'b1;

  always_comb begin
    unique case (st.src)
      SRC_K:   srcVal = kVal;
      SRC_MEM: srcVal = scratch[mIdx];
      SRC_EXT: srcVal = fetchData;
      SRC_ALU: srcVal = aluResult;
      SRC_A:   srcVal = regA;
      SRC_X:   srcVal = regX;
      default: srcVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (progWe) progMem[progAddr] <= progData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA <= '0; regX <= '0; pc <= '0; progTop <= '0; acceptLen <= '0;
      for (int i = 0; i < MEM_WORDS; i++) scratch[i] <= '0;
    end else begin
      if (progWe) begin
        if (progAddr == '0)          progTop <= 1;
        else if (addrNext > progTop) progTop <= addrNext;
      end
      if (st.clearAll) begin
        regA <= '0; regX <= '0; pc <= '0;
        for (int i = 0; i < MEM_WORDS; i++) scratch[i] <= '0;
      end
      if (st.wrA)   regA <= srcVal;
      if (st.wrX)   regX <= srcVal;
      if (st.wrMem) scratch[mIdx] <= st.memFromX ? regX : regA;
      if (st.pcStep)   pc <= pc + 1'b1;
      if (st.pcJump)   pc <= pc + 1'b1 + PC_W'(kVal);
      if (st.pcBranch) pc <= pc + 1'b1 + PC_W'(st.takeTrue ? jt : jf);
      if (st.finish)
        acceptLen <= st.retZero ? '0 : (st.retA ? regA : kVal);
    end
  end
endmodule

// File: rtl/bpfSeq.sv
module bpfSeq
  import bpfSeqPkg::*;
#(
  parameter int PROG_DEPTH = 64,
  parameter int MEM_WORDS  = 16,
  localparam int ADDR_W = $clog2(PROG_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progWe,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [63:0]       progData,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [31:0]       acceptLen,
  output logic              err,
  output logic              fetchReq,
  output logic [15:0]       fetchOp,
  output logic [31:0]       fetchK,
  output logic [31:0]       fetchIdx,
  input  logic              fetchDone,
  input  logic [31:0]       fetchData,
  output logic              aluReq,
  output logic [15:0]       aluOp,
  output logic [31:0]       aluA,
  output logic [31:0]       aluB,
  input  logic              aluDone,
  input  logic [31:0]       aluResult,
  input  logic              aluTrue
);
  seqStrobeT   st;
  logic [15:0] opcode;
  logic [31:0] kVal, regA, regX;
  logic        pcOk;

  seqCtrl u_ctrl (
    .clk, .rstN, .start, .op(opcode[7:0]), .pcOk, .fetchDone, .aluDone,
    .aluTrue, .st, .busy, .done, .err, .fetchReq, .aluReq
  );

  seqData #(.PROG_DEPTH(PROG_DEPTH), .MEM_WORDS(MEM_WORDS)) u_data (
    .clk, .rstN, .st, .progWe, .progAddr, .progData, .fetchData, .aluResult,
    .opcode, .kVal, .regA, .regX, .aluB, .pcOk, .acceptLen
  );

  assign fetchOp  = opcode;
  assign fetchK   = kVal;
  assign fetchIdx = regX;
  assign aluOp    = opcode;
  assign aluA     = regA;
endmodule

// File: rtl/bpfSeqChecker.sv
module bpfSeqChecker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [31:0] acceptLen,
  input logic        fetchReq,
  input logic        fetchDone,
  input logic [15:0] fetchOp,
  input logic [31:0] fetchK,
  input logic [31:0] fetchIdx,
  input logic        aluReq,
  input logic        aluDone,
  input logic [15:0] aluOp,
  input logic [31:0] aluA,
  input logic [31:0] aluB
);
  a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  a_r2_done_when_busy_falls: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  a_r2_done_is_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r5_fetch_held: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !fetchDone) |=> fetchReq && $stable(fetchOp) && $stable(fetchK) && $stable(fetchIdx));
  a_r6_alu_held: assert property (@(posedge clk) disable iff (!rstN)
    (aluReq && !aluDone) |=> aluReq && $stable(aluOp) && $stable(aluA) && $stable(aluB));
  a_r5_one_request: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchReq && aluReq));
  a_r10_fault_zero_len: assert property (@(posedge clk) disable iff (!rstN)
    (done && err) |-> acceptLen == 32'd0);
endmodule

bind bpfSeq bpfSeqChecker u_chk (.*);

// File: tb/bpfSeq_bench.sv
module bpfSeq_bench;
  localparam int DEPTH = 64;
  localparam logic [31:0] PKT_LEN = 32'd100;

  logic clk = 1'b0, rstN = 1'b0;
  logic progWe = 1'b0, start = 1'b0;
  logic [5:0] progAddr = '0;
  logic [63:0] progData = '0;
  logic busy, done, err, fetchReq, aluReq, aluTrue = 1'b0;
  logic fetchDone = 1'b0, aluDone = 1'b0;
  logic [31:0] acceptLen, fetchK, fetchIdx, fetchData = '0, aluA, aluB, aluResult = '0;
  logic [15:0] fetchOp, aluOp;

  always #2 clk = ~clk;

  bpfSeq u_bpfSeq (.*);

  int checks = 0, errors = 0;
  int fLat = 0, aLat = 0;
  logic [63:0] tp [DEPTH];
  int tn = 0;
  logic [31:0] expLen;
  logic expErr;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pb(logic [31:0] i);
    logic [31:0] t = i * 32'd37 + 32'd11;
    return t[7:0];
  endfunction

  function automatic logic [31:0] pr(logic [31:0] i, logic [1:0] sz);
    case (sz)
      2'd0:    return {pb(i), pb(i + 1), pb(i + 2), pb(i + 3)};
      2'd1:    return {16'h0, pb(i), pb(i + 1)};
      default: return {24'h0, pb(i)};
    endcase
  endfunction

  function automatic logic [31:0] fetchCalc(logic [15:0] op, logic [31:0] k, logic [31:0] x);
    case (op[7:5])
      3'd1:    return pr(k, op[4:3]);
      3'd2:    return pr(x + k, op[4:3]);
      3'd4:    return PKT_LEN;
      default: return {26'h0, pb(k)[3:0], 2'b00};
    endcase
  endfunction

  function automatic logic [32:0] aluCalc(logic [15:0] op, logic [31:0] a, logic [31:0] b);
    if (op[2:0] == 3'd5) begin
      case (op[7:4])
        4'd1:    return {a == b, 32'h0};
        4'd2:    return {a > b, 32'h0};
        4'd3:    return {a >= b, 32'h0};
        4'd4:    return {(a & b) != 0, 32'h0};
        default: return 33'h0;
      endcase
    end
    case (op[7:4])
      4'd0: return {1'b0, a + b};
      4'd1: return {1'b0, a - b};
      4'd2: return {1'b0, a * b};
      4'd3: return {1'b0, (b == 0) ? 32'h0 : a / b};
      4'd4: return {1'b0, a | b};
      4'd5: return {1'b0, a & b};
      4'd6: return {1'b0, a << b};
      4'd7: return {1'b0, a >> b};
      default: return {1'b0, -a};
    endcase
  endfunction

  // Reference interpreter built from the requirements
  function automatic void refRun();
    longint pc = 0;
    logic [31:0] a = 0, x = 0, k;
    logic [31:0] m [16];
    logic [15:0] op;
    logic [32:0] r;
    bit bad;
    for (int i = 0; i < 16; i++) m[i] = 0;
    expErr = 1'b1; expLen = 0;
    for (int s = 0; s < 500; s++) begin
      if (pc >= tn) return;
      op = tp[pc][63:48]; k = tp[pc][31:0];
      bad = 0;
      case (op[2:0])
        3'd0: case (op[7:5])
                3'd0: a = k;
                3'd1, 3'd2, 3'd4: a = fetchCalc(op, k, x);
                3'd3: a = m[k[3:0]];
                default: bad = 1;
              endcase
        3'd1: case (op[7:5])
                3'd0: x = k;
                3'd3: x = m[k[3:0]];
                3'd4, 3'd5: x = fetchCalc(op, k, x);
                default: bad = 1;
              endcase
        3'd2: m[k[3:0]] = a;
        3'd3: m[k[3:0]] = x;
        3'd4: begin r = aluCalc(op, a, op[3] ? x : k); a = r[31:0]; end
        3'd6: begin expErr = 0; expLen = op[4] ? a : k; return; end
        3'd7: if (op[7]) a = x; else x = a;
        default: ;
      endcase
      if (bad) return;
      if (op[2:0] == 3'd5) begin
        if (op[7:4] == 0) pc = pc + 1 + longint'(k);
        else begin
          r = aluCalc(op, a, op[3] ? x : k);
          pc = pc + 1 + longint'(r[32] ? tp[pc][47:40] : tp[pc][39:32]);
        end
      end else pc = pc + 1;
    end
  endfunction

  function automatic logic [15:0] opc(logic [4:0] hi, logic [2:0] cls);
    return {8'h0, hi, cls};
  endfunction

  task automatic put(int i, logic [15:0] op, logic [7:0] jt, logic [7:0] jf, logic [31:0] k);
    tp[i] = {op, jt, jf, k};
    if (i + 1 > tn) tn = i + 1;
  endtask

  // Environment models of the two neighbour units
  initial forever begin
    @(negedge clk);
    if (fetchReq) begin
      repeat (fLat) @(negedge clk);
      fetchData = fetchCalc(fetchOp, fetchK, fetchIdx);
      fetchDone = 1'b1;
      @(negedge clk);
      fetchDone = 1'b0;
    end
  end

  initial forever begin
    logic [32:0] r;
    @(negedge clk);
    if (aluReq) begin
      repeat (aLat) @(negedge clk);
      r = aluCalc(aluOp, aluA, aluB);
      aluResult = r[31:0]; aluTrue = r[32];
      aluDone = 1'b1;
      @(negedge clk);
      aluDone = 1'b0;
    end
  end

  task automatic runProg(string req, bit midStart);
    int n = 0, extra = 0;
    bit busyOk = 1, got = 0;
    logic [31:0] gotLen = 0;
    logic gotErr = 0;
    refRun();
    for (int i = 0; i < tn; i++) begin
      @(negedge clk);
      progWe = 1'b1; progAddr = 6'(i); progData = tp[i];
    end
    @(negedge clk); progWe = 1'b0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (n < 3000) begin
      if (done) begin got = 1; gotLen = acceptLen; gotErr = err; start = 1'b0; break; end
      if (!busy) busyOk = 0;
      start = (midStart && n == 2) ? 1'b1 : 1'b0;
      n++;
      @(negedge clk);
    end
    repeat (4) begin @(negedge clk); if (done) extra++; end
    chk(got, {req, " run finished"}, 32'(got), 32'd1);
    chk(gotLen == expLen, {req, " acceptLen"}, gotLen, expLen);
    chk(gotErr == expErr, {req, " err"}, 32'(gotErr), 32'(expErr));
    chk(busyOk, "R2 busy held until done", 32'(busyOk), 32'd1);
    if (midStart) chk(extra == 0, "R2 start while busy ignored", 32'(extra), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err, "R1 reset state", {29'h0, busy, done, err}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err, "R1 idle after reset", {29'h0, busy, done, err}, 32'd0);

    tn = 0; put(0, opc(5'b00000, 3'd6), 0, 0, 32'd60);
    runProg("R9 return k", 0);
    tn = 0; put(0, opc(5'b00000, 3'd0), 0, 0, 32'd0); put(1, opc(5'b00010, 3'd6), 0, 0, 32'd77);
    runProg("R9 return A zero drop", 0);

    tn = 0;
    put(0, opc(5'b00000, 3'd0), 0, 0, 32'd5);
    put(1, opc(5'b00000, 3'd2), 0, 0, 32'd3);
    put(2, opc(5'b00000, 3'd1), 0, 0, 32'd7);
    put(3, opc(5'b00000, 3'd3), 0, 0, 32'd20);
    put(4, opc(5'b00000, 3'd0), 0, 0, 32'd0);
    put(5, opc(5'b01100, 3'd0), 0, 0, 32'd19);
    put(6, opc(5'b01100, 3'd1), 0, 0, 32'd4);
    put(7, opc(5'b00000, 3'd4), 0, 0, 32'd0);
    put(8, opc(5'b00001, 3'd4), 0, 0, 32'd0);
    put(9, opc(5'b00010, 3'd6), 0, 0, 32'd0);
    runProg("R3 scratch alias", 0);

    tn = 0;
    put(0, opc(5'b00000, 3'd0), 0, 0, 32'h1234);
    put(1, opc(5'b00000, 3'd7), 0, 0, 32'd0);
    put(2, opc(5'b00000, 3'd0), 0, 0, 32'd0);
    put(3, opc(5'b10000, 3'd7), 0, 0, 32'd0);
    put(4, opc(5'b00010, 3'd6), 0, 0, 32'd0);
    runProg("R4 register transfer", 0);

    fLat = 2;
    tn = 0;
    put(0, opc(5'b00101, 3'd0), 0, 0, 32'd12);
    put(1, opc(5'b10110, 3'd1), 0, 0, 32'd14);
    put(2, opc(5'b01010, 3'd0), 0, 0, 32'd2);
    put(3, opc(5'b00001, 3'd4), 0, 0, 32'd0);
    put(4, opc(5'b00010, 3'd6), 0, 0, 32'd0);
    runProg("R5 packet loads", 0);
    fLat = 0;
    tn = 0;
    put(0, opc(5'b10000, 3'd1), 0, 0, 32'd0);
    put(1, opc(5'b10000, 3'd7), 0, 0, 32'd0);
    put(2, opc(5'b00010, 3'd6), 0, 0, 32'd0);
    runProg("R5 length load", 0);

    aLat = 1;
    tn = 0;
    put(0, opc(5'b00000, 3'd0), 0, 0, 32'd6);
    put(1, opc(5'b00000, 3'd1), 0, 0, 32'd7);
    put(2, opc(5'b00101, 3'd4), 0, 0, 32'd0);
    put(3, opc(5'b00000, 3'd4), 0, 0, 32'd3);
    put(4, opc(5'b00010, 3'd6), 0, 0, 32'd0);
    runProg("R6 alu chain", 0);
    chk(expLen == 32'd45, "R6 reference value", expLen, 32'd45);

    tn = 0;
    put(0, opc(5'b00000, 3'd0), 0, 0, 32'd9);
    put(1, opc(5'b00010, 3'd5), 1, 0, 32'd9);
    put(2, opc(5'b00000, 3'd6), 0, 0, 32'd1);
    put(3, opc(5'b00000, 3'd6), 0, 0, 32'd2);
    runProg("R7 branch true", 0);
    chk(expLen == 32'd2, "R7 reference true", expLen, 32'd2);
    tp[1][31:0] = 32'd8;
    runProg("R7 branch false falls through", 0);
    tp[1] = {opc(5'b00100, 3'd5), 8'd0, 8'd0, 32'd1};
    runProg("R7 zero offsets", 0);

    tn = 0;
    put(0, opc(5'b00000, 3'd5), 0, 0, 32'd2);
    put(1, opc(5'b00000, 3'd6), 0, 0, 32'd1);
    put(2, opc(5'b00000, 3'd6), 0, 0, 32'd2);
    put(3, opc(5'b00000, 3'd6), 0, 0, 32'd3);
    runProg("R8 skip", 0);
    chk(expLen == 32'd3, "R8 reference", expLen, 32'd3);
    tp[0][31:0] = 32'hFFFF_FFF0;
    runProg("R8 R10 huge skip", 0);

    tn = 0;
    put(0, opc(5'b00000, 3'd0), 0, 0, 32'd4);
    runProg("R10 R11 short reload past end", 0);
    tn = 0;
    put(0, opc(5'b11000, 3'd0), 0, 0, 32'd4);
    put(1, opc(5'b00000, 3'd6), 0, 0, 32'd9);
    runProg("R10 undefined opcode", 0);
    tn = 0;
    put(0, opc(5'b00100, 3'd1), 0, 0, 32'd4);
    put(1, opc(5'b00000, 3'd6), 0, 0, 32'd9);
    runProg("R10 undefined index load", 0);

    fLat = 3; aLat = 3;
    tn = 0;
    put(0, opc(5'b00101, 3'd0), 0, 0, 32'd4);
    put(1, opc(5'b00000, 3'd4), 0, 0, 32'd1);
    put(2, opc(5'b00010, 3'd6), 0, 0, 32'd0);
    runProg("R2 busy restart", 1);

    for (int t = 0; t < 60; t++) begin
      int n = 4 + int'($urandom % 12);
      fLat = int'($urandom % 4); aLat = int'($urandom % 4);
      tn = 0;
      for (int i = 0; i < n; i++) begin
        r = $urandom;
        case (r % 10)
          0: put(i, opc(5'b00000, 3'd0), 0, 0, $urandom % 50);
          1: put(i, opc({($urandom % 2) ? 3'd1 : 3'd2, 2'($urandom % 3)}, 3'd0), 0, 0, $urandom % 32);
          2: put(i, opc({(r[8]) ? 3'd4 : 3'd5, 2'd2}, 3'd1), 0, 0, $urandom % 32);
          3: put(i, opc(5'b00000, r[9] ? 3'd3 : 3'd2), 0, 0, $urandom % 32);
          4: put(i, opc(5'b01100, r[9] ? 3'd1 : 3'd0), 0, 0, $urandom % 32);
          5: put(i, opc({4'($urandom % 9), r[10]}, 3'd4), 0, 0, 1 + $urandom % 9);
          6: put(i, opc({4'(1 + $urandom % 4), r[10]}, 3'd5), 8'($urandom % 4), 8'($urandom % 4), $urandom % 60);
          7: put(i, opc(5'b00000, 3'd5), 0, 0, $urandom % 3);
          8: put(i, opc({r[11], 4'b0000}, 3'd7), 0, 0, 0);
          default: put(i, opc({3'd0, r[12], 1'b0}, 3'd6), 0, 0, $urandom % 200);
        endcase
      end
      if ($urandom % 4 != 0) put(n, opc(5'b00010, 3'd6), 0, 0, 0);
      runProg("R7 R9 random program", 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule